// File: doc/BRIEF.md
# Horizontal line timer with digital sync insertion

This block sets the horizontal line timing for a video output path and builds the code sent to a video DAC. A pixel counter runs from 1 up to a programmable line length and then returns to 1. Each return to 1 starts a new line and begins the horizontal sync pulse. The sync pulse lasts for a programmable number of pixel clocks, counted from that restart.

In each pixel clock the block picks one of three levels for the DAC. During sync it drives the blank level lowered by a programmable depth. During blanking outside sync it drives the blank level. During active time it passes the incoming video sample. A setup option adds a fixed pedestal to both the blank level and active video outside sync. The pedestal is never added during sync. The counter, the sync flag and a line-start strobe are also brought out, so that neighbouring logic can align to the line.

Top module: `hsync_inserter`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the counter is loaded with 1. With a nonzero sync width, the cycle after that edge shows `h_count_o`=1, `sync_o`=1 and `line_start_o`=1.
- R2: Outside reset, when the counter is below the effective line length it increments by 1 at each clock. When it is at or above the effective line length it returns to 1. The effective line length is `line_len_i`, or 1 when `line_len_i` is 0.
- R3: `line_start_o` is high exactly in the cycles where `h_count_o` equals 1. With a line length above 1, it is high for a single clock.
- R4: `sync_o` is high exactly while 1 ≤ `h_count_o` ≤ the effective width. For nonzero values, the effective width is `sync_width_i` limited to the effective line length.
- R5: A `sync_width_i` of 0 keeps `sync_o` low on every count, so no sync level is ever output.
- R6: A `sync_width_i` larger than the effective line length holds `sync_o` high for the whole line.
- R7: While `sync_o` is high, `dac_code_o` equals BLANK_LVL minus `sync_amp_i`, with a floor of 0. Each unit of `sync_amp_i` lowers the code by one LSB. `video_i`, `blank_i` and `setup_en_i` have no effect in these cycles.
- R8: While `sync_o` is low and `blank_i` is 1, `dac_code_o` equals BLANK_LVL. When `setup_en_i` is 1 it equals BLANK_LVL+PED_LVL instead, saturating at the DAC full scale.
- R9: While `sync_o` is low and `blank_i` is 0, `dac_code_o` equals `video_i`. When `setup_en_i` is 1, PED_LVL is added, and the result saturates at 2^DAC_W−1.
- R10: Lowering `line_len_i` below the current count makes the counter return to 1 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset; restarts the line |
| video_i | input | DAC_W | Incoming video sample code |
| blank_i | input | 1 | High when the sample lies in blanking |
| setup_en_i | input | 1 | Adds the setup pedestal outside sync |
| line_len_i | input | CNT_W | Terminal count of the pixel counter |
| sync_width_i | input | WID_W | Sync duration in pixel clocks, 0 = off |
| sync_amp_i | input | AMP_W | Sync depth below blank, in DAC LSBs |
| dac_code_o | output | DAC_W | Composed code for the DAC |
| h_count_o | output | CNT_W | Horizontal pixel counter, 1-based |
| sync_o | output | 1 | High during horizontal sync |
| line_start_o | output | 1 | High for the first pixel of each line |

## Verification
Sync and blanking can be active in the same cycle, and so can sync and active video. To provoke this, the bench toggles `blank_i`, `setup_en_i` and the video samples all through the sync windows. It then checks that the sync level wins in every such cycle and that the pedestal stays out. A second overlap is a line-length change that lands on the wrap cycle, or below the running count. This is judged against a cycle-by-cycle model of the counter that recomputes the effective width from the new length.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    localparam int DEF_CNT_W = 12;
    localparam int DEF_WID_W = 8;
    localparam int DEF_AMP_W = 8;
    localparam int DEF_DAC_W = 10;

    // Which level the composer places on the DAC in a given pixel
    typedef enum logic [1:0] {
        LVL_ACTIVE = 2'd0,
        LVL_BLANK  = 2'd1,
        LVL_SYNC   = 2'd2
    } level_e;

    // Addition that saturates at a ceiling
    function automatic int unsigned sat_add(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned ceil_v);
        int unsigned s;
        s = a + b;
        return (s > ceil_v) ? ceil_v : s;
    endfunction

    // Subtraction that stops at zero
    function automatic int unsigned floor_sub(input int unsigned a,
                                              input int unsigned b);
        return (b > a) ? 32'd0 : (a - b);
    endfunction

endpackage

// File: rtl/hline_counter.sv
module hline_counter
    import hsync_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int WID_W = DEF_WID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] line_len_i,
    input  logic [WID_W-1:0] width_i,
    output logic [CNT_W-1:0] count_o,
    output logic             line_start_o,
    output logic             sync_o
);

    localparam int CMP_W = (CNT_W > WID_W) ? CNT_W : WID_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CMP_W-1:0] lim_ext;
    logic [CMP_W-1:0] wid_ext;
    logic [CMP_W-1:0] eff_wid;
    logic [CMP_W-1:0] cnt_ext;

    // A zero length behaves like a one-pixel line
    assign limit = (line_len_i == '0) ? CNT_W'(1) : line_len_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(1);
        end else if (cnt_q >= limit) begin
            cnt_q <= CNT_W'(1);
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sync window: from the restart up to the width, never past the line
    assign lim_ext = CMP_W'(limit);
    assign wid_ext = CMP_W'(width_i);
    assign cnt_ext = CMP_W'(cnt_q);
    assign eff_wid = (wid_ext > lim_ext) ? lim_ext : wid_ext;

    assign count_o      = cnt_q;
    assign line_start_o = (cnt_q == CNT_W'(1));
    assign sync_o       = (width_i != '0) && (cnt_ext <= eff_wid);

    AST_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= limit) |=> (cnt_q == CNT_W'(1))); // R2 R10

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < limit) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q != '0)); // R2

endmodule

// File: rtl/sync_composer.sv
module sync_composer
    import hsync_pkg::*;
#(
    parameter int DAC_W     = DEF_DAC_W,
    parameter int AMP_W     = DEF_AMP_W,
    parameter int BLANK_LVL = 256,
    parameter int PED_LVL   = 28
) (
    input  logic [DAC_W-1:0] video_i,
    input  logic             blank_i,
    input  logic             setup_i,
    input  logic             sync_i,
    input  logic [AMP_W-1:0] amp_i,
    output logic [DAC_W-1:0] code_o
);

    localparam int unsigned DAC_MAX = (32'd1 << DAC_W) - 32'd1;
    localparam int unsigned BLK_U   = BLANK_LVL;
    localparam int unsigned PED_U   = PED_LVL;

    level_e      lvl;
    int unsigned ped;
    int unsigned val;

    // Sync takes priority over blanking, blanking over active video
    always_comb begin
        if (sync_i) begin
            lvl = LVL_SYNC;
        end else if (blank_i) begin
            lvl = LVL_BLANK;
        end else begin
            lvl = LVL_ACTIVE;
        end
    end

    assign ped = setup_i ? PED_U : 32'd0;

    always_comb begin
        case (lvl)
            LVL_SYNC:  val = floor_sub(BLK_U, 32'(amp_i));
            LVL_BLANK: val = sat_add(BLK_U, ped, DAC_MAX);
            default:   val = sat_add(32'(video_i), ped, DAC_MAX);
        endcase
    end

    assign code_o = DAC_W'(val);

endmodule

// File: rtl/hsync_inserter.sv
module hsync_inserter
    import hsync_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int WID_W     = DEF_WID_W,
    parameter int AMP_W     = DEF_AMP_W,
    parameter int DAC_W     = DEF_DAC_W,
    parameter int BLANK_LVL = 256,
    parameter int PED_LVL   = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DAC_W-1:0] video_i,
    input  logic             blank_i,
    input  logic             setup_en_i,
    input  logic [CNT_W-1:0] line_len_i,
    input  logic [WID_W-1:0] sync_width_i,
    input  logic [AMP_W-1:0] sync_amp_i,
    output logic [DAC_W-1:0] dac_code_o,
    output logic [CNT_W-1:0] h_count_o,
    output logic             sync_o,
    output logic             line_start_o
);

    logic sync_w;

    hline_counter #(
        .CNT_W (CNT_W),
        .WID_W (WID_W)
    ) u_counter (
        .clk          (clk),
        .rst          (rst),
        .line_len_i   (line_len_i),
        .width_i      (sync_width_i),
        .count_o      (h_count_o),
        .line_start_o (line_start_o),
        .sync_o       (sync_w)
    );

    sync_composer #(
        .DAC_W     (DAC_W),
        .AMP_W     (AMP_W),
        .BLANK_LVL (BLANK_LVL),
        .PED_LVL   (PED_LVL)
    ) u_composer (
        .video_i (video_i),
        .blank_i (blank_i),
        .setup_i (setup_en_i),
        .sync_i  (sync_w),
        .amp_i   (sync_amp_i),
        .code_o  (dac_code_o)
    );

    assign sync_o = sync_w;

    AST_SYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
        (line_start_o && (sync_width_i != '0)) |-> sync_o); // R4

    AST_NO_SYNC_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (sync_width_i == '0) |-> !sync_o); // R5

    AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (sync_o && (int'(sync_amp_i) <= BLANK_LVL))
            |-> (int'(dac_code_o) == BLANK_LVL - int'(sync_amp_i))); // R7

    AST_SYNC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (sync_o && (int'(sync_amp_i) > BLANK_LVL)) |-> (dac_code_o == '0)); // R7

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (line_start_o && (line_len_i > CNT_W'(1))) |=> !line_start_o); // R3

endmodule

// File: tb/test_hsync_inserter.sv
module test_hsync_inserter;

    localparam int CLK_PERIOD = 10;
    localparam int CW  = 12;
    localparam int WW  = 8;
    localparam int AW  = 8;
    localparam int DW  = 10;
    localparam int BLK = 200;
    localparam int PED = 30;
    localparam int FULL = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] video = '0;
    logic          blank = 1'b0;
    logic          setup = 1'b0;
    logic [CW-1:0] len = 12'd10;
    logic [WW-1:0] wid = 8'd3;
    logic [AW-1:0] amp = 8'd40;
    logic [DW-1:0] dac;
    logic [CW-1:0] hcnt;
    logic          sync;
    logic          lstart;

    int n_total = 0;
    int n_fail  = 0;
    int ref_cnt = 1;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsync_inserter #(
        .CNT_W(CW), .WID_W(WW), .AMP_W(AW), .DAC_W(DW),
        .BLANK_LVL(BLK), .PED_LVL(PED)
    ) i_hsync_inserter (
        .clk(clk), .rst(rst), .video_i(video), .blank_i(blank),
        .setup_en_i(setup), .line_len_i(len), .sync_width_i(wid),
        .sync_amp_i(amp), .dac_code_o(dac), .h_count_o(hcnt),
        .sync_o(sync), .line_start_o(lstart)
    );

    function automatic int eff_len(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (count model %0d)", tag, what, act, exp, ref_cnt);
        end
    endtask

    // Compare this cycle against the model, then advance the model over one edge
    task automatic tick(input string tag);
        int l, w, es, code;
        #(CLK_PERIOD/4);
        l  = eff_len(int'(len));
        w  = (int'(wid) > l) ? l : int'(wid);
        es = (wid != 0 && ref_cnt <= w) ? 1 : 0;
        if (es != 0)
            code = (int'(amp) > BLK) ? 0 : BLK - int'(amp);
        else if (blank)
            code = (BLK + (setup ? PED : 0) > FULL) ? FULL : BLK + (setup ? PED : 0);
        else
            code = (int'(video) + (setup ? PED : 0) > FULL) ? FULL : int'(video) + (setup ? PED : 0);
        check(tag, "h_count", int'(hcnt), ref_cnt);
        check(tag, "sync", int'(sync), es);
        check(tag, "line_start", int'(lstart), (ref_cnt == 1) ? 1 : 0);
        check(tag, "dac_code", int'(dac), code);
        @(posedge clk);
        if (rst) ref_cnt = 1;
        else if (ref_cnt >= l) ref_cnt = 1;
        else ref_cnt++;
        @(negedge clk);
    endtask

    task automatic run(input string tag, input int n, input bit vary);
        for (int i = 0; i < n; i++) begin
            if (vary) begin
                video = DW'($urandom_range(0, FULL));
                blank = ($urandom_range(0, 3) == 0);
                setup = ($urandom_range(0, 1) == 1);
            end
            tick(tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        ref_cnt = 1;
        // R1: reset state held
        run("R1", 3, 1'b0);
        rst = 1'b0;
        // R2: counting and wrapping, mixed stimulus
        run("R2", 25, 1'b1);
        // R3: line start on short lines
        len = 12'd5; wid = 8'd2;
        run("R3", 14, 1'b1);
        // R4: sync window of five pixels
        len = 12'd12; wid = 8'd5;
        run("R4", 26, 1'b1);
        // R5: zero width disables sync
        wid = 8'd0;
        run("R5", 14, 1'b1);
        // R6: width above line length
        len = 12'd16; wid = 8'd200;
        run("R6", 34, 1'b1);
        // R7: deep sync clamps, shallow sync subtracts; blank/setup toggled in sync
        len = 12'd9; wid = 8'd4; amp = 8'd255;
        run("R7", 20, 1'b1);
        amp = 8'd150;
        run("R7", 20, 1'b1);
        // R8: blanking level with and without pedestal
        amp = 8'd40; blank = 1'b1; setup = 1'b0;
        run("R8", 10, 1'b0);
        setup = 1'b1;
        run("R8", 10, 1'b0);
        // R9: active video, pedestal saturation near full scale
        blank = 1'b0; setup = 1'b1; video = 10'd1010;
        run("R9", 10, 1'b0);
        setup = 1'b0; video = 10'd1023;
        run("R9", 10, 1'b0);
        // R10: shorten the line below the count, then zero length
        len = 12'd40; wid = 8'd3;
        run("R10", 30, 1'b1);
        len = 12'd6;
        run("R10", 14, 1'b1);
        len = 12'd0;
        run("R10", 6, 1'b1);
        // R1: reset in the middle of a line restarts it
        len = 12'd20;
        run("R1", 11, 1'b1);
        rst = 1'b1;
        run("R1", 1, 1'b1);
        rst = 1'b0;
        run("R1", 8, 1'b1);
        // R2: maximum line length wraps after 4095
        len = 12'd4095; wid = 8'd255;
        run("R2", 4110, 1'b1);
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule